// File: doc/BRIEF.md
# Buck Converter Start-Up and Protection Sequencer

This block is the digital sequencer of a fixed-frequency buck controller. It runs on the system clock and moves forward only on cycles where the oscillator tick enable is high. The analog side gives it four comparator results as logic levels:
- the supply is above the upper power-on threshold;
- the supply is above the lower power-on threshold;
- the compensation node is above its enable level;
- the feedback voltage is below the under-voltage trip level.

From these the sequencer runs a power-on delay and then a stepped soft-start ramp, then normal regulation. It also handles external shutdown and a latched under-voltage fault.

Its outputs are a reference code, a PWM enable and a fault flag. The reference code drives the DAC that stands in for the fixed reference during start-up. The PWM enable gates the drivers. When start-up is over, the code sits at the full reference value. An under-voltage trip in regulation turns both gates off. The converter then stays off until the supply drops below the lower threshold.

Top module: `softstart_seq`

## Requirements
- R1: After reset, `ref_code`=0, `pwm_en`=0 and `fault`=0. Nothing starts while `vcc_hi` is low, whatever the other inputs are.
- R2: Start needs `vcc_hi` and `comp_on` both high. The block then waits DELAY_TICKS oscillator ticks (default 1024) with `pwm_en` low. If `comp_on` is low, it stays off.
- R3: On the tick that ends the delay, `pwm_en` goes to 1 with `ref_code`=0. After that, `ref_code` rises by exactly 1 every STEP_TICKS ticks (default 16).
- R4: `ref_code` reaches REF_CODE (default 64) after REF_CODE steps. It then holds at REF_CODE with `pwm_en`=1, and it never exceeds REF_CODE.
- R5: Clock cycles with `osc_tick` low do not advance the delay or the ramp.
- R6: `fb_low` is ignored during the delay and during the ramp.
- R7: `fb_low` high during regulation gives `fault`=1, `pwm_en`=0 and `ref_code`=0 one cycle later. This state is latched: neither `comp_on` toggles nor ticks clear it.
- R8: `comp_on` low during the delay, the ramp or regulation gives `pwm_en`=0 and `ref_code`=0 one cycle later. When `comp_on` returns high, the full delay and ramp run again from zero.
- R9: Once started, dropping `vcc_hi` alone has no effect. `vcc_ok` low returns the block to the reset state one cycle later, which also clears `fault`. A new start then needs `vcc_hi` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| vcc_hi | input | 1 | Supply above the upper power-on threshold |
| vcc_ok | input | 1 | Supply above the lower power-on threshold |
| comp_on | input | 1 | Compensation node above its enable level |
| fb_low | input | 1 | Feedback below the under-voltage trip level |
| ref_code | output | 7 | Reference code for the DAC |
| pwm_en | output | 1 | Gate drivers enabled |
| fault | output | 1 | Latched under-voltage fault |

## Verification
The hardest state to reach is an under-voltage trip that must survive shutdown toggles and several thousand ticks. It is only reachable after a full delay and ramp, more than two thousand irregular ticks. The bench issues ticks with random idle gaps, holding `fb_low` randomly high throughout start-up so that the ignore window is exercised. It then trips the fault in regulation and toggles `comp_on` before cycling the lower supply flag. A second start is cut off by shutdown in mid-ramp, which shows that the restart runs from the very beginning.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAIT = 3'd1,
    ST_RAMP = 3'd2,
    ST_RUN  = 3'd3,
    ST_HOLD = 3'd4,
    ST_TRIP = 3'd5
  } seq_state_e;
endpackage

// File: rtl/ss_tick_counter.sv
module ss_tick_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit_m1,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == limit_m1);
  assign wrap   = tick && at_end && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (tick)   cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/ss_ramp_code.sv
module ss_ramp_code #(
  parameter int CODE_W   = 7,
  parameter int REF_CODE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [CODE_W-1:0] code,
  output logic              last_step
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(REF_CODE);

  logic [CODE_W-1:0] code_q, code_d;

  assign code      = code_q;
  assign last_step = step && (code_q == TOP - 1'b1);

  always_comb begin
    code_d = code_q;
    if (clr)                      code_d = '0;
    else if (step && code_q < TOP) code_d = code_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  AST_CODE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= TOP); // R4
  AST_CODE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> (code_q == $past(code_q) + 1'b1 || code_q == '0)); // R3
endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
  import softstart_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int REF_CODE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcc_hi,
  input  logic              vcc_ok,
  input  logic              comp_on,
  input  logic              fb_low,
  input  logic              wrap,
  input  logic              last_step,
  input  logic [CODE_W-1:0] ramp_code,
  output logic              in_wait,
  output logic              in_ramp,
  output logic              cnt_clr,
  output logic              ramp_clr,
  output logic [CODE_W-1:0] ref_code,
  output logic              pwm_en,
  output logic              fault
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!vcc_ok) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:  if (vcc_hi) st_d = comp_on ? ST_WAIT : ST_HOLD;
        ST_HOLD: if (comp_on) st_d = ST_WAIT;
        ST_WAIT: if (!comp_on) st_d = ST_HOLD;
                 else if (wrap) st_d = ST_RAMP;
        ST_RAMP: if (!comp_on) st_d = ST_HOLD;
                 else if (last_step) st_d = ST_RUN;
        ST_RUN:  if (!comp_on) st_d = ST_HOLD;
                 else if (fb_low) st_d = ST_TRIP;
        ST_TRIP: st_d = ST_TRIP;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign in_wait  = (st_q == ST_WAIT);
  assign in_ramp  = (st_q == ST_RAMP);
  assign cnt_clr  = !(in_wait || in_ramp);
  assign ramp_clr = !(in_ramp || st_q == ST_RUN);
  assign pwm_en   = in_ramp || (st_q == ST_RUN);
  assign fault    = (st_q == ST_TRIP);

  always_comb begin
    ref_code = '0;
    if (st_q == ST_RUN) ref_code = CODE_W'(REF_CODE);
    else if (in_ramp)   ref_code = ramp_code;
  end

  AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && vcc_ok) |=> fault); // R7
  AST_UV_TRIPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && ref_code == CODE_W'(REF_CODE) && fb_low && comp_on && vcc_ok) |=> (fault && !pwm_en)); // R7
  AST_UV_IGNORED_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ramp && fb_low && vcc_ok) |=> !fault); // R6
  AST_SHUTDOWN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_on |=> !pwm_en); // R8
  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> (!pwm_en && !fault)); // R9
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int DELAY_TICKS = 1024,
  parameter int STEP_TICKS  = 16,
  parameter int REF_CODE    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       vcc_hi,
  input  logic       vcc_ok,
  input  logic       comp_on,
  input  logic       fb_low,
  output logic [6:0] ref_code,
  output logic       pwm_en,
  output logic       fault
);
  localparam int CODE_W = 7;
  localparam int CNT_W  = (DELAY_TICKS > STEP_TICKS) ? $clog2(DELAY_TICKS) : $clog2(STEP_TICKS);
  localparam logic [CNT_W-1:0] DELAY_M1 = CNT_W'(DELAY_TICKS - 1);
  localparam logic [CNT_W-1:0] STEP_M1  = CNT_W'(STEP_TICKS - 1);

  logic              in_wait, in_ramp, cnt_clr, ramp_clr, wrap, last_step, step;
  logic [CNT_W-1:0]  limit_m1;
  logic [CODE_W-1:0] ramp_code;

  assign limit_m1 = in_wait ? DELAY_M1 : STEP_M1;
  assign step     = wrap && in_ramp;

  ss_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(osc_tick),
    .limit_m1(limit_m1), .wrap(wrap)
  );

  ss_ramp_code #(.CODE_W(CODE_W), .REF_CODE(REF_CODE)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .step(step),
    .code(ramp_code), .last_step(last_step)
  );

  ss_seq_fsm #(.CODE_W(CODE_W), .REF_CODE(REF_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .vcc_hi(vcc_hi), .vcc_ok(vcc_ok),
    .comp_on(comp_on), .fb_low(fb_low), .wrap(wrap), .last_step(last_step),
    .ramp_code(ramp_code), .in_wait(in_wait), .in_ramp(in_ramp),
    .cnt_clr(cnt_clr), .ramp_clr(ramp_clr), .ref_code(ref_code),
    .pwm_en(pwm_en), .fault(fault)
  );
endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;
  localparam int DLY = 1024;
  localparam int STP = 16;
  localparam int TOP = 64;

  logic clk = 1'b0;
  logic rst_n, osc_tick, vcc_hi, vcc_ok, comp_on, fb_low;
  logic [6:0] ref_code;
  logic pwm_en, fault;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  softstart_seq dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .vcc_hi(vcc_hi),
    .vcc_ok(vcc_ok), .comp_on(comp_on), .fb_low(fb_low),
    .ref_code(ref_code), .pwm_en(pwm_en), .fault(fault)
  );

  function automatic int exp_code(int ramp_ticks);
    return (ramp_ticks >= STP * TOP) ? TOP : ramp_ticks / STP;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ticks with random idle gaps; optional random fb_low noise
  task automatic ticks(int n, bit noise_fb);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1;
      if (noise_fb) fb_low = 1'($urandom_range(0, 1));
      @(negedge clk);
      osc_tick = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
      finish_run();
    end
  end

  initial begin
    int acc;
    void'($urandom(32'd1234));
    rst_n = 0; osc_tick = 0; vcc_hi = 0; vcc_ok = 0; comp_on = 1; fb_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 code", ref_code, 0);
    chk("R1 pwm", pwm_en, 0);
    chk("R1 fault", fault, 0);

    // R1: only lower threshold present, no start
    vcc_ok = 1;
    ticks(1200, 1'b1);
    chk("R1 no start without vcc_hi", pwm_en, 0);
    fb_low = 0;

    // R2: comp low at power-up keeps it off
    comp_on = 0; vcc_hi = 1;
    @(negedge clk);
    ticks(1100, 1'b0);
    chk("R2 comp low holds off", pwm_en, 0);
    comp_on = 1;
    @(negedge clk);

    // R2/R6: delay with fb_low noise
    ticks(DLY - 1, 1'b1);
    chk("R2 delay pwm off", pwm_en, 0);
    chk("R6 no fault in delay", fault, 0);
    ticks(1, 1'b1);
    chk("R3 pwm at ramp start", pwm_en, 1);
    chk("R3 code at ramp start", ref_code, 0);

    // R5: idle cycles do not advance
    repeat (STP * 3) @(negedge clk);
    chk("R5 idle no advance", ref_code, 0);

    // R3/R6: random chunks through the ramp
    acc = 0;
    while (acc < STP * TOP) begin
      int n = $urandom_range(1, 40);
      if (acc + n > STP * TOP) n = STP * TOP - acc;
      ticks(n, 1'b1);
      acc += n;
      chk("R3 ramp code", ref_code, exp_code(acc));
      chk("R6 no fault in ramp", fault, 0);
    end
    fb_low = 0;
    @(negedge clk);
    chk("R4 code at top", ref_code, TOP);
    ticks(100, 1'b0);
    chk("R4 code holds", ref_code, TOP);
    chk("R4 pwm held", pwm_en, 1);

    // R9: upper flag drop alone is harmless
    vcc_hi = 0;
    ticks(20, 1'b0);
    chk("R9 vcc_hi drop ignored", pwm_en, 1);

    // R7: trip in regulation
    fb_low = 1;
    @(negedge clk);
    fb_low = 0;
    chk("R7 fault set", fault, 1);
    chk("R7 pwm off", pwm_en, 0);
    chk("R7 code zero", ref_code, 0);
    comp_on = 0; repeat (4) @(negedge clk); comp_on = 1;
    ticks(2 * DLY + 50, 1'b0);
    chk("R7 fault latched over comp toggle", fault, 1);
    chk("R7 pwm stays off", pwm_en, 0);

    // R9: lower flag drop clears fault; restart needs vcc_hi
    vcc_ok = 0;
    @(negedge clk);
    chk("R9 fault cleared", fault, 0);
    vcc_ok = 1;
    ticks(DLY + 20, 1'b0);
    chk("R9 needs vcc_hi again", pwm_en, 0);

    // R8: shutdown mid-ramp then full restart
    vcc_hi = 1;
    @(negedge clk);
    ticks(DLY + 300, 1'b0);
    chk("R8 pre-shutdown code", ref_code, exp_code(300));
    comp_on = 0;
    @(negedge clk);
    chk("R8 pwm off", pwm_en, 0);
    chk("R8 code zero", ref_code, 0);
    comp_on = 1;
    @(negedge clk);
    ticks(DLY - 1, 1'b0);
    chk("R8 full delay again", pwm_en, 0);
    ticks(1 + STP, 1'b0);
    chk("R8 ramp restarts at zero", ref_code, 1);

    // R8: shutdown during regulation
    ticks(STP * TOP, 1'b0);
    chk("R4 top second start", ref_code, TOP);
    comp_on = 0;
    @(negedge clk);
    chk("R8 shutdown in run", pwm_en, 0);
    finish_run();
  end
endmodule